// File: doc/BRIEF.md
# Flit Packetizer and Source Queue

This block sits between a traffic source and the local input of one network router. A packet request names the destination node, the packet length in flits, a packet identifier and a virtual channel. The block breaks the packet into head, body and tail flits of a fixed 32-bit layout and writes them, one per cycle, into a local source queue. From the queue it drives one flit per cycle into the router's local port whenever the downstream virtual channel holds a credit.

The head flit carries the first-hop output port. This port is worked out with X-then-Y dimension ordering from the node's own coordinates, which are set by parameters. Each head or single-flit packet leaves with a 16-bit injection timestamp, so that a receiver can measure latency. When the queue cannot take a whole packet, the request is held off and not lost.

Top module: `flit_injector`

## Requirements
- R1: The flit type sits in bits [31:30]: 00 head, 01 body, 10 tail, 11 single. A packet of n>=2 flits leaves as one head, n-2 bodies and one tail. A request length of 1 or 0 gives one single-type flit.
- R2: Bits [29:28] of every flit of a packet carry the requested virtual channel.
- R3: A head or single flit holds the following fields:
  - [27:25] the first-hop output port
  - [24:22] the own X coordinate
  - [21:19] the own Y coordinate
  - [18:16] the destination X coordinate
  - [15:13] the destination Y coordinate
  - [12:5] the packet ID
  - [4:0] zero

  Body and tail flits have bits [27:0] at zero.
- R4: The first-hop port is chosen in this order. It is 1 (east) if destination X > own X, and 2 (west) if destination X < own X. Otherwise it is 3 (north) if destination Y > own Y, 4 (south) if destination Y < own Y, and 0 (local) when both coordinates match.
- R5: A request is taken in a cycle where req_valid and req_ready are both high. req_ready is high only when no earlier packet is still being written and the free queue slots number at least the effective length.
- R6: A request that is held off is delayed, never dropped. Every flit of every accepted packet leaves in acceptance order.
- R7: The credit count starts at CREDITS and rises by one on each credit_in pulse. A flit leaves only while the count is nonzero. At most one flit leaves per cycle.
- R8: With an empty queue and credit available, the first flit appears on out_flit in the cycle after the second rising edge, counting the accepting edge as the first. The rest of the packet's flits follow back to back.
- R9: While a head or single flit is on the port, inj_time equals the number of rising edges since reset release, modulo 2^16.
- R10: After reset, out_valid is low, inj_time is zero, and req_ready is high for any length up to the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Request can be taken |
| req_dst_x | input | 3 | Destination X |
| req_dst_y | input | 3 | Destination Y |
| req_len | input | 5 | Packet length in flits (0 treated as 1) |
| req_pid | input | 8 | Packet ID |
| req_vc | input | 2 | Virtual channel |
| out_valid | output | 1 | Flit on out_flit this cycle |
| out_flit | output | 32 | Flit to router local port |
| credit_in | input | 1 | One credit returned |
| inj_time | output | 16 | Injection timestamp of the current head |

## Verification
The request is accepted on one rising edge, and the head is in the queue after that edge. It is popped on the next edge and is visible in the cycle that follows, so the bench expects the first flit at the accepting edge count plus one. The bench samples on falling edges and logs each flit with its edge count, which checks both that latency and the back-to-back spacing of the remaining flits. Backpressure is also checked at fixed points. req_ready must read low one falling edge after a multi-flit packet is accepted. The flit count must stay frozen at the credit limit for a stretch of cycles while credits are withheld.

// File: rtl/flit_injector.sv
module flit_injector #(
  parameter int FLIT_W  = 32,
  parameter int VC_W    = 2,
  parameter int PORT_W  = 3,
  parameter int COORD_W = 3,
  parameter int PID_W   = 8,
  parameter int LEN_W   = 5,
  parameter int DEPTH   = 16,
  parameter int CREDITS = 4,
  parameter int TIME_W  = 16,
  parameter int SRC_X   = 2,
  parameter int SRC_Y   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_dst_x,
  input  logic [COORD_W-1:0] req_dst_y,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [VC_W-1:0]    req_vc,
  output logic               out_valid,
  output logic [FLIT_W-1:0]  out_flit,
  input  logic               credit_in,
  output logic [TIME_W-1:0]  inj_time
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int KW    = $clog2(CREDITS + 1);
  localparam int T_LO  = FLIT_W - 2;
  localparam int V_LO  = T_LO - VC_W;
  localparam int P_LO  = V_LO - PORT_W;
  localparam int SX_LO = P_LO - COORD_W;
  localparam int SY_LO = SX_LO - COORD_W;
  localparam int DX_LO = SY_LO - COORD_W;
  localparam int DY_LO = DX_LO - COORD_W;
  localparam int ID_LO = DY_LO - PID_W;

  localparam logic [1:0] K_HEAD = 2'b00;
  localparam logic [1:0] K_BODY = 2'b01;
  localparam logic [1:0] K_TAIL = 2'b10;
  localparam logic [1:0] K_SOLO = 2'b11;

  localparam logic [PORT_W-1:0] GO_LOCAL = PORT_W'(0);
  localparam logic [PORT_W-1:0] GO_EAST  = PORT_W'(1);
  localparam logic [PORT_W-1:0] GO_WEST  = PORT_W'(2);
  localparam logic [PORT_W-1:0] GO_NORTH = PORT_W'(3);
  localparam logic [PORT_W-1:0] GO_SOUTH = PORT_W'(4);

  localparam logic [COORD_W-1:0] MY_X = COORD_W'(SRC_X);
  localparam logic [COORD_W-1:0] MY_Y = COORD_W'(SRC_Y);

  logic [FLIT_W-1:0]  mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic [CW-1:0]      cnt;
  logic [KW-1:0]      cred;
  logic [TIME_W-1:0]  timer;
  logic               busy;
  logic [LEN_W-1:0]   left;
  logic [VC_W-1:0]    vc_q;
  logic [LEN_W-1:0]   len_eff;
  logic               accept, push, pop, pop_is_head;
  logic [PORT_W-1:0]  route;
  logic [FLIT_W-1:0]  head_flit, seg_flit, push_flit;

  assign len_eff     = (req_len == '0) ? LEN_W'(1) : req_len;
  assign req_ready   = !busy && ((32'(DEPTH) - 32'(cnt)) >= 32'(len_eff));
  assign accept      = req_valid && req_ready;
  assign push        = accept || busy;
  assign pop         = (cnt != '0) && (cred != '0);
  assign pop_is_head = mem[rp][FLIT_W-1] == mem[rp][FLIT_W-2];
  assign push_flit   = accept ? head_flit : seg_flit;

  always_comb begin
    if (req_dst_x > MY_X)      route = GO_EAST;
    else if (req_dst_x < MY_X) route = GO_WEST;
    else if (req_dst_y > MY_Y) route = GO_NORTH;
    else if (req_dst_y < MY_Y) route = GO_SOUTH;
    else                       route = GO_LOCAL;
  end

  always_comb begin
    head_flit = '0;
    head_flit[FLIT_W-1 -: 2]    = (len_eff == LEN_W'(1)) ? K_SOLO : K_HEAD;
    head_flit[V_LO +: VC_W]     = req_vc;
    head_flit[P_LO +: PORT_W]   = route;
    head_flit[SX_LO +: COORD_W] = MY_X;
    head_flit[SY_LO +: COORD_W] = MY_Y;
    head_flit[DX_LO +: COORD_W] = req_dst_x;
    head_flit[DY_LO +: COORD_W] = req_dst_y;
    head_flit[ID_LO +: PID_W]   = req_pid;
  end

  always_comb begin
    seg_flit = '0;
    seg_flit[FLIT_W-1 -: 2] = (left == LEN_W'(1)) ? K_TAIL : K_BODY;
    seg_flit[V_LO +: VC_W]  = vc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      vc_q <= '0;
    end else if (accept) begin
      busy <= len_eff > LEN_W'(1);
      left <= len_eff - LEN_W'(1);
      vc_q <= req_vc;
    end else if (busy) begin
      left <= left - LEN_W'(1);
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_flit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      cred <= KW'(CREDITS);
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt  <= cnt + CW'(push) - CW'(pop);
      cred <= cred - KW'(pop) + KW'(credit_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      inj_time  <= '0;
      timer     <= '0;
    end else begin
      timer     <= timer + TIME_W'(1);
      out_valid <= pop;
      if (pop) out_flit <= mem[rp];
      if (pop && pop_is_head) inj_time <= timer + TIME_W'(1);
    end
  end
endmodule

// File: rtl/flit_injector_chk.sv
module flit_injector_chk #(
  parameter int FLIT_W  = 32,
  parameter int VC_W    = 2,
  parameter int PORT_W  = 3,
  parameter int COORD_W = 3,
  parameter int LEN_W   = 5,
  parameter int CREDITS = 4,
  parameter int TIME_W  = 16,
  parameter int SRC_X   = 2,
  parameter int SRC_Y   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              credit_in,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_flit,
  input logic [TIME_W-1:0] inj_time
);
  localparam int V_LO  = FLIT_W - 2 - VC_W;
  localparam int SX_LO = V_LO - PORT_W - COORD_W;
  localparam int SY_LO = SX_LO - COORD_W;

  int                chk_cred;
  logic              in_pkt;
  logic [TIME_W-1:0] tmr;
  logic [1:0]        ty;
  logic              is_head, is_seg;

  assign ty      = out_flit[FLIT_W-1 -: 2];
  assign is_head = out_valid && (ty == 2'b00 || ty == 2'b11);
  assign is_seg  = ty == 2'b01 || ty == 2'b10;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_cred <= CREDITS;
      in_pkt   <= 1'b0;
      tmr      <= '0;
    end else begin
      chk_cred <= chk_cred - int'(out_valid) + int'(credit_in);
      tmr      <= tmr + TIME_W'(1);
      if (out_valid) in_pkt <= (ty == 2'b00) || (ty == 2'b01);
    end
  end

  assert_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> chk_cred > 0);
  assert_ready_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len > LEN_W'(1)) |=> !req_ready);
  assert_seg_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_seg) |-> out_flit[V_LO-1:0] == '0);
  assert_head_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_head |-> (out_flit[SX_LO +: COORD_W] == COORD_W'(SRC_X) &&
                 out_flit[SY_LO +: COORD_W] == COORD_W'(SRC_Y)));
  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_pkt == is_seg));
  assert_stamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_head |-> inj_time == tmr);
endmodule

bind flit_injector flit_injector_chk #(
  .FLIT_W(FLIT_W), .VC_W(VC_W), .PORT_W(PORT_W), .COORD_W(COORD_W),
  .LEN_W(LEN_W), .CREDITS(CREDITS), .TIME_W(TIME_W),
  .SRC_X(SRC_X), .SRC_Y(SRC_Y)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .credit_in(credit_in), .out_valid(out_valid),
  .out_flit(out_flit), .inj_time(inj_time)
);

// File: tb/flit_injector_tb.sv
module flit_injector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_dst_x = '0, req_dst_y = '0;
  logic [4:0]  req_len = 5'd1;
  logic [7:0]  req_pid = '0;
  logic [1:0]  req_vc = '0;
  logic        out_valid;
  logic [31:0] out_flit;
  logic        credit_in = 1'b0;
  logic [15:0] inj_time;

  int errors = 0, checks = 0, tcount = 0, rx_n = 0, owed = 0;
  bit release_c = 1'b1, done = 1'b0;
  logic [31:0] rx_f [64];
  int          rx_t [64];
  logic [15:0] rx_s [64];

  // {dst_x, dst_y, len, pid, vc, expected first-hop port}; own node is (2,1)
  localparam logic [23:0] VEC [6] = '{
    {3'd5, 3'd0, 5'd3, 8'h11, 2'd1, 3'd1},
    {3'd0, 3'd6, 5'd1, 8'h22, 2'd2, 3'd2},
    {3'd2, 3'd4, 5'd2, 8'h33, 2'd3, 3'd3},
    {3'd2, 3'd0, 5'd4, 8'h44, 2'd0, 3'd4},
    {3'd2, 3'd1, 5'd0, 8'hFF, 2'd1, 3'd0},
    {3'd7, 3'd7, 5'd5, 8'h5A, 2'd2, 3'd1}
  };

  flit_injector dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dst_x(req_dst_x), .req_dst_y(req_dst_y), .req_len(req_len),
    .req_pid(req_pid), .req_vc(req_vc), .out_valid(out_valid),
    .out_flit(out_flit), .credit_in(credit_in), .inj_time(inj_time)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk);
    if (!rst_n) tcount = 0; else tcount++;
  end

  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      credit_in = 1'b0;
      owed = 0;
    end else begin
      if (out_valid && rx_n < 64) begin
        rx_f[rx_n] = out_flit;
        rx_t[rx_n] = tcount;
        rx_s[rx_n] = inj_time;
        rx_n++;
        owed++;
      end
      if (release_c && owed > 0) begin
        credit_in = 1'b1;
        owed--;
      end else credit_in = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flit(input int j, input int n, input logic [2:0] dx,
      input logic [2:0] dy, input logic [7:0] pid, input logic [1:0] vc, input logic [2:0] port);
    logic [1:0] ty;
    ty = (n == 1) ? 2'b11 : (j == 0) ? 2'b00 : (j == n - 1) ? 2'b10 : 2'b01;
    if (j == 0) return {ty, vc, port, 3'd2, 3'd1, dx, dy, pid, 5'd0};
    return {ty, vc, 28'd0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rx_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [2:0] dx, input logic [2:0] dy, input logic [4:0] len,
      input logic [7:0] pid, input logic [1:0] vc, output int acc);
    int g = 0;
    @(negedge clk);
    req_dst_x = dx; req_dst_y = dy; req_len = len; req_pid = pid; req_vc = vc;
    req_valid = 1'b1;
    #1;
    while (!req_ready && g < 2000) begin
      @(negedge clk); #1; g++;
    end
    acc = tcount + 1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (len > 1) chk(req_ready == 1'b0, "R5 busy after accept", 32'(req_ready), 0);
  endtask

  task automatic wait_rx(input int n);
    int g = 0;
    while (rx_n < n && g < 500) begin
      @(negedge clk); g++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rx_n, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int acc, base, n;
    logic [2:0] dx, dy, pt;
    logic [4:0] ln;
    logic [7:0] pid;
    logic [1:0] vc;

    do_reset();
    @(negedge clk); #1;
    req_len = 5'd16;
    #1;
    chk(out_valid == 1'b0, "R10 out_valid low", 32'(out_valid), 0);
    chk(req_ready == 1'b1, "R10 ready for full depth", 32'(req_ready), 1);
    chk(inj_time == 16'd0, "R10 inj_time zero", 32'(inj_time), 0);

    for (int v = 0; v < 6; v++) begin
      {dx, dy, ln, pid, vc, pt} = VEC[v];
      n = (ln == 0) ? 1 : int'(ln);
      base = rx_n;
      send(dx, dy, ln, pid, vc, acc);
      wait_rx(base + n);
      chk(rx_n == base + n, "R6 flit count", 32'(rx_n), 32'(base + n));
      for (int j = 0; j < n; j++)
        chk(rx_f[base + j] == exp_flit(j, n, dx, dy, pid, vc, pt), "R1 R2 R3 R4 flit content",
            rx_f[base + j], exp_flit(j, n, dx, dy, pid, vc, pt));
      chk(rx_t[base] == acc + 1, "R8 first flit latency", 32'(rx_t[base]), 32'(acc + 1));
      if (n > 1)
        chk(rx_t[base + n - 1] == rx_t[base] + n - 1, "R8 back to back",
            32'(rx_t[base + n - 1]), 32'(rx_t[base] + n - 1));
      chk(rx_s[base] == 16'(rx_t[base]), "R9 injection stamp", 32'(rx_s[base]), 32'(rx_t[base]));
      repeat (3) @(negedge clk);
    end

    release_c = 1'b0;
    do_reset();
    send(3'd3, 3'd1, 5'd8, 8'h61, 2'd1, acc);
    repeat (15) @(negedge clk);
    chk(rx_n == 4, "R7 stall at credit limit", 32'(rx_n), 4);
    send(3'd0, 3'd1, 5'd8, 8'h62, 2'd2, acc);
    repeat (12) @(negedge clk);
    chk(rx_n == 4, "R7 no flit without credit", 32'(rx_n), 4);
    req_valid = 1'b0;
    req_len = 5'd8;
    #1;
    chk(req_ready == 1'b0, "R5 no room for 8", 32'(req_ready), 0);
    req_len = 5'd4;
    #1;
    chk(req_ready == 1'b1, "R5 room for 4", 32'(req_ready), 1);
    release_c = 1'b1;
    send(3'd2, 3'd3, 5'd8, 8'h63, 2'd3, acc);
    wait_rx(24);
    chk(rx_n == 24, "R6 held packet delivered", 32'(rx_n), 24);
    for (int j = 0; j < 8; j++) begin
      chk(rx_f[j] == exp_flit(j, 8, 3'd3, 3'd1, 8'h61, 2'd1, 3'd1), "R6 packet A order",
          rx_f[j], exp_flit(j, 8, 3'd3, 3'd1, 8'h61, 2'd1, 3'd1));
      chk(rx_f[8 + j] == exp_flit(j, 8, 3'd0, 3'd1, 8'h62, 2'd2, 3'd2), "R6 packet B order",
          rx_f[8 + j], exp_flit(j, 8, 3'd0, 3'd1, 8'h62, 2'd2, 3'd2));
      chk(rx_f[16 + j] == exp_flit(j, 8, 3'd2, 3'd3, 8'h63, 2'd3, 3'd3), "R6 packet C order",
          rx_f[16 + j], exp_flit(j, 8, 3'd2, 3'd3, 8'h63, 2'd3, 3'd3));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule